// File: doc/BRIEF.md
# Shared Packet-Buffer FIFO Partitioner

This block carves a single packet buffer RAM of 16 KB into four circular FIFOs. Queue 0 holds outbound payload and command words. Queue 1 holds outbound status. Queue 2 holds inbound payload and queue 3 holds inbound status. A size setting, counted in whole kilobytes, decides how much of the RAM goes to the outbound side. The block derives the base address and depth of each region from that setting. It keeps a read offset, a write offset and a fill count for every queue and maps them onto the shared memory.

A host writes a new size only while both the transmit and receive engines are idle. Each accepted setting clears every queue. Data moves through one write port and one read port, and a selector on each port picks the queue. One word can be pushed and one popped per clock, into or out of any queues. A popped word appears on the data output in the cycle after the pop request, together with a valid strobe.

The RAM is organised as 64-bit words, so one kilobyte is 128 words and each status region is 64 words. With the default parameters the address width AW is 11 and a fill count is AW+1 = 12 bits wide.

Top module: `fifo_part_mgr`

## Requirements
- R1: After synchronous reset the size setting reads 5. All four queues are empty with level 0 and none is full. The overflow, underflow and configuration-error flags are clear, and pop_valid is 0.
- R2: For a size setting S, the queue depths in 64-bit words are as follows. Queue 0 holds S*128-64 words and queue 1 holds 64 words, both inside the lowest S KB. Queue 2 holds (16-S)*128-64 words and queue 3 holds 64 words at the top of the RAM. A queue flags full exactly when its level equals its depth.
- R3: Each queue returns words in the order they were pushed, including across the wrap of its region. A pop of a non-empty queue presents its oldest word on pop_data with pop_valid high in the following cycle. pop_valid is low in every cycle that follows no accepted pop.
- R4: The level of a queue rises by one for each accepted push and falls by one for each accepted pop. A push and a pop to the same queue in one cycle leave the level unchanged. empty is high exactly when the level is 0, and a queue is never full and empty at once.
- R5: A push to a full queue is dropped and the queue contents stay intact. It sets that queue's overflow bit, which stays set until reset.
- R6: A pop from an empty queue is dropped and produces no pop_valid. It sets that queue's underflow bit, which stays set until reset.
- R7: A size write while tx_active or rx_active is high is ignored. The size setting and the contents of every queue stay unchanged, and cfg_error is set and stays set until reset.
- R8: An accepted size value below 2 is applied as 2, and a value above 14 is applied as 14. size_units never leaves the range 2 to 14.
- R9: An accepted size write empties all four queues at the following clock edge. A push or pop in the same cycle as that write is discarded without setting any flag.
- R10: The four regions never overlap. With all queues filled to their depth at the smallest and the largest size, each queue drains back exactly its own words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Size write strobe |
| cfg_size | input | 4 | Requested outbound allocation in KB |
| tx_active | input | 1 | Transmit engine running |
| rx_active | input | 1 | Receive engine running |
| size_units | output | 4 | Applied outbound allocation in KB |
| cfg_error | output | 1 | Sticky: size write attempted while active |
| push_en | input | 1 | Push request |
| push_sel | input | 2 | Queue selected for push (0..3) |
| push_data | input | 64 | Word to push |
| pop_en | input | 1 | Pop request |
| pop_sel | input | 2 | Queue selected for pop (0..3) |
| pop_valid | output | 1 | pop_data holds a popped word |
| pop_data | output | 64 | Popped word |
| full | output | 4 | Per-queue full, bit q for queue q |
| empty | output | 4 | Per-queue empty |
| level | output | 48 | Per-queue fill count, 12 bits each, queue q at bits 12q+11..12q |
| overflow | output | 4 | Sticky per-queue overflow |
| underflow | output | 4 | Sticky per-queue underflow |

## Verification
The hardest states to reach from the ports are the region edges under extreme sizes. These are queue 2 at its 1728-word depth when the size is 2, and queue 0 at its 1728-word depth when the size is 14. Both must hold while the neighbouring regions are full as well. Directed sequences apply each extreme size and fill all four queues word by word, each word tagged with its queue and index, to exactly their depth. They then drain every queue, so an overlap or a wrong boundary shows up as a wrong word. Seeded random traffic, biased toward pushes, then drives the small status queues repeatedly through wrap, full and empty. Occasional size writes in that traffic land while the engines are busy.

// File: rtl/fifo_part_pkg.sv
package fifo_part_pkg;
  localparam int NQ     = 4;
  localparam int QSEL_W = 2;
  // queue indices; the region order in memory follows this numbering
  localparam int Q_TXD = 0;
  localparam int Q_TXS = 1;
  localparam int Q_RXD = 2;
  localparam int Q_RXS = 3;
endpackage

// File: rtl/fifo_part_map.sv
module fifo_part_map
  import fifo_part_pkg::*;
#(
  parameter int UNITS       = 16,
  parameter int UNIT_WORDS  = 128,
  parameter int STAT_WORDS  = 64,
  parameter int MIN_UNITS   = 2,
  parameter int MAX_UNITS   = 14,
  parameter int RST_UNITS   = 5,
  parameter int SZ_W        = 4,
  parameter int AW          = 11,
  parameter int CW          = 12
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cfg_wr,
  input  logic                   busy,
  input  logic [SZ_W-1:0]        cfg_size,
  output logic                   apply,
  output logic [SZ_W-1:0]        size_q,
  output logic                   cfg_err,
  output logic [NQ-1:0][AW-1:0]  base_q,
  output logic [NQ-1:0][CW-1:0]  depth_q
);
  localparam int TOTAL = UNITS * UNIT_WORDS;

  logic [SZ_W-1:0] clamped;
  logic [SZ_W-1:0] size_nxt;
  logic [CW-1:0]   tx_words;

  always_comb begin
    if (cfg_size < SZ_W'(MIN_UNITS))      clamped = SZ_W'(MIN_UNITS);
    else if (cfg_size > SZ_W'(MAX_UNITS)) clamped = SZ_W'(MAX_UNITS);
    else                                  clamped = cfg_size;
    apply    = cfg_wr & ~busy;
    size_nxt = rst ? SZ_W'(RST_UNITS) : clamped;
    tx_words = CW'(size_nxt) * CW'(UNIT_WORDS);
  end

  always_ff @(posedge clk) begin
    if (rst)                 cfg_err <= 1'b0;
    else if (cfg_wr && busy) cfg_err <= 1'b1;

    if (rst || apply) begin
      size_q         <= size_nxt;
      base_q[Q_TXD]  <= '0;
      depth_q[Q_TXD] <= tx_words - CW'(STAT_WORDS);
      base_q[Q_TXS]  <= AW'(tx_words - CW'(STAT_WORDS));
      depth_q[Q_TXS] <= CW'(STAT_WORDS);
      base_q[Q_RXD]  <= AW'(tx_words);
      depth_q[Q_RXD] <= CW'(TOTAL) - tx_words - CW'(STAT_WORDS);
      base_q[Q_RXS]  <= AW'(TOTAL - STAT_WORDS);
      depth_q[Q_RXS] <= CW'(STAT_WORDS);
    end
  end
endmodule

// File: rtl/fifo_part_ptr.sv
module fifo_part_ptr #(
  parameter int AW = 11,
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          push,
  input  logic          pop,
  input  logic [AW-1:0] base,
  input  logic [CW-1:0] depth,
  output logic [AW-1:0] wr_addr,
  output logic [AW-1:0] rd_addr,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty,
  output logic          ovf,
  output logic          udf,
  output logic          push_ok,
  output logic          pop_ok
);
  logic [AW-1:0] wr_off, rd_off;

  function automatic logic [AW-1:0] step_off(input logic [AW-1:0] off, input logic [CW-1:0] dep);
    return (CW'(off) + CW'(1) == dep) ? '0 : off + AW'(1);
  endfunction

  assign full    = (count == depth);
  assign empty   = (count == '0);
  assign push_ok = push & ~full;
  assign pop_ok  = pop & ~empty;
  assign wr_addr = base + wr_off;
  assign rd_addr = base + rd_off;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wr_off <= '0;
      rd_off <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_off <= step_off(wr_off, depth);
      if (pop_ok)  rd_off <= step_off(rd_off, depth);
      case ({push_ok, pop_ok})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ovf <= 1'b0;
      udf <= 1'b0;
    end else begin
      if (push && full) ovf <= 1'b1;
      if (pop && empty) udf <= 1'b1;
    end
  end
endmodule

// File: rtl/fifo_part_ram.sv
module fifo_part_ram #(
  parameter int DW = 64,
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 2 ** AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/fifo_part_mgr.sv
module fifo_part_mgr
  import fifo_part_pkg::*;
#(
  parameter int DATA_W     = 64,
  parameter int UNITS      = 16,
  parameter int UNIT_WORDS = 128,
  parameter int STAT_WORDS = 64,
  parameter int MIN_UNITS  = 2,
  parameter int MAX_UNITS  = 14,
  parameter int RST_UNITS  = 5,
  localparam int TOTAL     = UNITS * UNIT_WORDS,
  localparam int AW        = $clog2(TOTAL),
  localparam int CW        = AW + 1,
  localparam int SZ_W      = $clog2(UNITS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_wr,
  input  logic [SZ_W-1:0]      cfg_size,
  input  logic                 tx_active,
  input  logic                 rx_active,
  output logic [SZ_W-1:0]      size_units,
  output logic                 cfg_error,
  input  logic                 push_en,
  input  logic [QSEL_W-1:0]    push_sel,
  input  logic [DATA_W-1:0]    push_data,
  input  logic                 pop_en,
  input  logic [QSEL_W-1:0]    pop_sel,
  output logic                 pop_valid,
  output logic [DATA_W-1:0]    pop_data,
  output logic [NQ-1:0]        full,
  output logic [NQ-1:0]        empty,
  output logic [NQ*CW-1:0]     level,
  output logic [NQ-1:0]        overflow,
  output logic [NQ-1:0]        underflow
);
  logic                 apply;
  logic                 busy;
  logic [NQ-1:0]        push_req, pop_req, push_ok, pop_ok;
  logic [NQ-1:0][AW-1:0] base, wr_addr, rd_addr;
  logic [NQ-1:0][CW-1:0] depth, cnt;

  assign busy = tx_active | rx_active;

  fifo_part_map #(
    .UNITS(UNITS), .UNIT_WORDS(UNIT_WORDS), .STAT_WORDS(STAT_WORDS),
    .MIN_UNITS(MIN_UNITS), .MAX_UNITS(MAX_UNITS), .RST_UNITS(RST_UNITS),
    .SZ_W(SZ_W), .AW(AW), .CW(CW)
  ) u_map (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .busy(busy), .cfg_size(cfg_size),
    .apply(apply), .size_q(size_units), .cfg_err(cfg_error),
    .base_q(base), .depth_q(depth)
  );

  for (genvar q = 0; q < NQ; q++) begin : g_q
    assign push_req[q] = push_en && (push_sel == QSEL_W'(q)) && !apply;
    assign pop_req[q]  = pop_en  && (pop_sel  == QSEL_W'(q)) && !apply;

    fifo_part_ptr #(.AW(AW), .CW(CW)) u_ptr (
      .clk(clk), .rst(rst), .clr(apply),
      .push(push_req[q]), .pop(pop_req[q]),
      .base(base[q]), .depth(depth[q]),
      .wr_addr(wr_addr[q]), .rd_addr(rd_addr[q]), .count(cnt[q]),
      .full(full[q]), .empty(empty[q]),
      .ovf(overflow[q]), .udf(underflow[q]),
      .push_ok(push_ok[q]), .pop_ok(pop_ok[q])
    );

    assign level[q*CW +: CW] = cnt[q];
  end

  fifo_part_ram #(.DW(DATA_W), .AW(AW)) u_ram (
    .clk(clk),
    .we(|push_ok), .waddr(wr_addr[push_sel]), .wdata(push_data),
    .re(|pop_ok),  .raddr(rd_addr[pop_sel]),  .rdata(pop_data)
  );

  always_ff @(posedge clk) begin
    if (rst) pop_valid <= 1'b0;
    else     pop_valid <= |pop_ok;
  end
endmodule

// File: rtl/fifo_part_mgr_chk.sv
module fifo_part_mgr_chk #(
  parameter int SZ_W      = 4,
  parameter int MIN_UNITS = 2,
  parameter int MAX_UNITS = 14
) (
  input logic            clk,
  input logic            rst,
  input logic            cfg_wr,
  input logic            tx_active,
  input logic            rx_active,
  input logic [SZ_W-1:0] size_units,
  input logic            cfg_error,
  input logic            pop_en,
  input logic [1:0]      pop_sel,
  input logic            pop_valid,
  input logic [3:0]      full,
  input logic [3:0]      empty,
  input logic [3:0]      overflow,
  input logic [3:0]      underflow
);
  logic busy_c, apply_c;
  assign busy_c  = tx_active | rx_active;
  assign apply_c = cfg_wr & ~busy_c;

  AST_FULL_NOT_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (full & empty) == 4'h0); // R4

  AST_NO_POP_FROM_EMPTY: assert property (@(posedge clk) disable iff (rst)
    pop_en && !apply_c && empty[pop_sel] |=> !pop_valid); // R6

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    ($past(overflow) & ~overflow) == 4'h0); // R5

  AST_UDF_STICKY: assert property (@(posedge clk) disable iff (rst)
    ($past(underflow) & ~underflow) == 4'h0); // R6

  AST_BUSY_CFG_IGNORED: assert property (@(posedge clk) disable iff (rst)
    cfg_wr && busy_c |=> $stable(size_units) && cfg_error); // R7

  AST_SIZE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    size_units >= SZ_W'(MIN_UNITS) && size_units <= SZ_W'(MAX_UNITS)); // R8

  AST_APPLY_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    apply_c |=> empty == 4'hF); // R9
endmodule

bind fifo_part_mgr fifo_part_mgr_chk #(
  .SZ_W(SZ_W), .MIN_UNITS(MIN_UNITS), .MAX_UNITS(MAX_UNITS)
) u_chk (
  .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .tx_active(tx_active),
  .rx_active(rx_active), .size_units(size_units), .cfg_error(cfg_error),
  .pop_en(pop_en), .pop_sel(pop_sel), .pop_valid(pop_valid),
  .full(full), .empty(empty), .overflow(overflow), .underflow(underflow)
);

// File: tb/fifo_part_mgr_tb_top.sv
module fifo_part_mgr_tb_top;
  localparam int DW = 64;
  localparam int CW = 12;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst, cfg_wr, tx_active, rx_active, push_en, pop_en, pop_valid, cfg_error;
  logic [3:0]    cfg_size, size_units, full, empty, overflow, underflow;
  logic [1:0]    push_sel, pop_sel;
  logic [DW-1:0] push_data, pop_data;
  logic [4*CW-1:0] level;

  fifo_part_mgr dut_i (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_size(cfg_size),
    .tx_active(tx_active), .rx_active(rx_active), .size_units(size_units),
    .cfg_error(cfg_error), .push_en(push_en), .push_sel(push_sel),
    .push_data(push_data), .pop_en(pop_en), .pop_sel(pop_sel),
    .pop_valid(pop_valid), .pop_data(pop_data), .full(full), .empty(empty),
    .level(level), .overflow(overflow), .underflow(underflow)
  );

  int total = 0;
  int bad   = 0;
  logic [DW-1:0] mq [4][$];
  int   exp_size;
  logic [3:0] exp_ovf, exp_udf;
  logic exp_cerr;

  function automatic int dep(input int q, input int s);
    case (q)
      0:       return s * 128 - 64;
      2:       return (16 - s) * 128 - 64;
      default: return 64;
    endcase
  endfunction

  function automatic int clampsz(input int s);
    return (s < 2) ? 2 : (s > 14) ? 14 : s;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // called at a falling edge; returns at the next falling edge after checking
  task automatic step(input bit pu, input int ps, input logic [63:0] pd,
                      input bit po, input int qs, input bit cw, input int cs);
    bit busy, ap, ev;
    logic [63:0] ed;
    int n_ps, n_qs;
    push_en = pu; push_sel = 2'(ps); push_data = pd;
    pop_en = po; pop_sel = 2'(qs); cfg_wr = cw; cfg_size = 4'(cs);
    busy = tx_active | rx_active;
    ap = cw && !busy;
    ev = 1'b0; ed = '0;
    n_ps = mq[ps].size(); n_qs = mq[qs].size();
    if (cw && busy) exp_cerr = 1'b1;
    if (ap) begin
      exp_size = clampsz(cs);
      for (int i = 0; i < 4; i++) mq[i].delete();
    end else begin
      if (po) begin
        if (n_qs == 0) exp_udf[qs] = 1'b1;
        else begin ev = 1'b1; ed = mq[qs].pop_front(); end
      end
      if (pu) begin
        if (n_ps >= dep(ps, exp_size)) exp_ovf[ps] = 1'b1;
        else mq[ps].push_back(pd);
      end
    end
    @(negedge clk);
    push_en = 1'b0; pop_en = 1'b0; cfg_wr = 1'b0;
    chk(pop_valid == ev, "R3", "pop_valid", 64'(pop_valid), 64'(ev));
    if (ev) chk(pop_data == ed, "R3", "pop_data order", pop_data, ed);
    chk(level[ps*CW +: CW] == CW'(mq[ps].size()), "R4", "level push queue",
        64'(level[ps*CW +: CW]), 64'(mq[ps].size()));
    chk(level[qs*CW +: CW] == CW'(mq[qs].size()), "R4", "level pop queue",
        64'(level[qs*CW +: CW]), 64'(mq[qs].size()));
    chk(full[ps] == (mq[ps].size() == dep(ps, exp_size)), "R2", "full at depth",
        64'(full[ps]), 64'(mq[ps].size() == dep(ps, exp_size)));
    chk(empty[qs] == (mq[qs].size() == 0), "R4", "empty",
        64'(empty[qs]), 64'(mq[qs].size() == 0));
    chk(overflow == exp_ovf, "R5", "overflow flags", 64'(overflow), 64'(exp_ovf));
    chk(underflow == exp_udf, "R6", "underflow flags", 64'(underflow), 64'(exp_udf));
    chk(cfg_error == exp_cerr, "R7", "cfg_error", 64'(cfg_error), 64'(exp_cerr));
    chk(size_units == 4'(exp_size), "R8", "size_units", 64'(size_units), 64'(exp_size));
    if (ap) chk(empty == 4'hF, "R9", "all empty after apply", 64'(empty), 64'hF);
  endtask

  task automatic push1(input int q, input logic [63:0] d);
    step(1'b1, q, d, 1'b0, q, 1'b0, 0);
  endtask
  task automatic pop1(input int q);
    step(1'b0, q, '0, 1'b1, q, 1'b0, 0);
  endtask
  task automatic cfg1(input int s);
    step(1'b0, 0, '0, 1'b0, 0, 1'b1, s);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    rst = 1'b1; cfg_wr = 0; cfg_size = 0; tx_active = 0; rx_active = 0;
    push_en = 0; push_sel = 0; push_data = 0; pop_en = 0; pop_sel = 0;
    exp_size = 5; exp_ovf = '0; exp_udf = '0; exp_cerr = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(size_units == 4'd5, "R1", "reset size", 64'(size_units), 64'd5);
    chk(empty == 4'hF && full == 4'h0, "R1", "reset empty/full",
        64'({full, empty}), 64'h0F);
    chk(level == '0, "R1", "reset level", 64'(level), 64'd0);
    chk({overflow, underflow, cfg_error, pop_valid} == '0, "R1", "reset flags",
        64'({overflow, underflow, cfg_error, pop_valid}), 64'd0);

    // R2/R5: fill queue 0 at size 5 (576 words) plus one extra, then R6 drain past empty
    for (int k = 0; k < 577; k++) push1(0, 64'hA000_0000 + 64'(k));
    for (int k = 0; k < 577; k++) pop1(0);

    // R7: size write while busy keeps setting and contents
    push1(3, 64'h5151);
    tx_active = 1'b1; cfg1(9); tx_active = 1'b0;
    rx_active = 1'b1; cfg1(3); rx_active = 1'b0;
    pop1(3);

    // R8 clamping, R9 apply discards stored data and same-cycle push
    push1(2, 64'h77);
    cfg1(0);
    step(1'b1, 1, 64'h99, 1'b0, 1, 1'b1, 15);
    cfg1(1);
    cfg1(7);

    // R10: all four regions to full at both extreme sizes, then drain
    for (int s = 2; s <= 14; s += 12) begin
      cfg1(s);
      for (int q = 0; q < 4; q++)
        for (int k = 0; k < dep(q, s); k++) push1(q, {32'(q), 32'(k)});
      for (int q = 0; q < 4; q++) push1(q, 64'hDEAD);
      for (int q = 0; q < 4; q++)
        for (int k = 0; k < dep(q, s); k++) pop1(q);
    end

    // random traffic with a fixed seed
    void'($urandom(32'h5EED_0042));
    cfg1(4);
    for (int n = 0; n < 8000; n++) begin
      tx_active = ($urandom % 6) == 0;
      rx_active = ($urandom % 6) == 0;
      step(($urandom % 10) < 6, int'($urandom % 4), {$urandom, $urandom},
           ($urandom % 10) < 4, int'($urandom % 4),
           ($urandom % 400) == 0, int'($urandom % 16));
    end
    tx_active = 1'b0; rx_active = 1'b0;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule